// File: doc/BRIEF.md
# Scoreboard Issue Control Unit

This block controls instruction issue for a single in-order instruction stream that feeds ten functional units sharing one register file. Each cycle it is offered at most one decoded instruction. The instruction carries a unit class, a destination register and two source registers. The block either accepts it into a free unit of that class or raises a stall. Once an instruction has been accepted, the block tells its unit when the operands may be read and when the result may be written.

Internally the block keeps a status table of result-pending registers, each entry tagged with the unit that will produce it. Each unit keeps its own source tags and ready flags. Each functional unit is modelled as a fixed-latency countdown that starts when the unit reads its operands. The controller enforces four hazard rules:

- A busy unit or an outstanding write to the same destination blocks issue.
- A missing operand delays the read grant.
- An earlier reader that has not yet taken an old register value delays a later writer's result.

Because of these rules, instructions leave the block in program order but may finish in any order. One write port is shared among all units, and ties are resolved by unit index.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all units are free, no register is pending, no read or write grant is raised, and a valid instruction is accepted at once.
- R2: The class field is encoded as 0 float multiply, 1 float add, 2 float divide, 3 integer add, 4 increment, 5 boolean, 6 shift, 7 branch. The units are 0–1 multiply, 2 add, 3 divide, 4 integer add, 5–6 increment, 7 boolean, 8 shift, 9 branch. An accepted instruction raises `issue_ok` and exactly one `issue_unit` bit, which is the lowest-index free unit of its class. `stall` equals valid and not accepted.
- R3: An instruction whose class has no free unit stalls, and it holds the stream in order until a unit of that class is free.
- R4: An instruction whose destination register still awaits a result from an issued instruction stalls until that result has been written.
- R5: A unit is granted its operand read no earlier than the cycle after issue. If a source awaits a producer, the read is granted no earlier than the cycle after that producer's write grant.
- R6: A unit's write to register d is withheld while another unit still waits to read d with its ready flag for d set.
- R7: With no conflicts, the write grant comes latency+1 cycles after the read grant. Latencies are: multiply 10, divide 29, float add 4, and all other classes 3.
- R8: At most one write grant is raised per cycle. Among eligible units, the lowest index wins, and the others wait.
- R9: A unit is free to accept a new instruction in the cycle after its write grant, and not before.
- R10: A later, shorter instruction may write its result before an earlier, longer one.
- R11: `wb_reg` shows the destination register of the unit holding the write grant, and `wb_valid` marks that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_class | input | 3 | Unit class of the offered instruction |
| in_dst | input | log2(NUM_REGS) | Destination register |
| in_src1 | input | log2(NUM_REGS) | First source register |
| in_src2 | input | log2(NUM_REGS) | Second source register |
| issue_ok | output | 1 | Instruction accepted this cycle |
| issue_unit | output | 10 | One-hot unit receiving the instruction |
| stall | output | 1 | Instruction offered but not accepted |
| read_grant | output | 10 | Per-unit operand read strobe |
| write_grant | output | 10 | Per-unit result write strobe |
| wb_valid | output | 1 | A result is written this cycle |
| wb_reg | output | log2(NUM_REGS) | Register written this cycle |

## Verification
An isolated integer add establishes the baseline timing from issue to read to write. A long divide followed by a short add shows that results can complete out of order. Three multiplies back to back exhaust the class, and an add followed by a boolean that targets the same register forces the output-dependency stall. A dependent add behind a multiply separates a held read from a held write. A divide–add–boolean chain creates a reader that is ready on one operand, which tells the write-after-read hold apart from the read-after-write one. Two units finishing in the same cycle, followed by a reissue to a unit that has just been released, show the write priority and the cycle in which the unit is free again.

// File: rtl/sb_pkg.sv
// Shared definitions for the scoreboard issue controller: unit classes,
// the fixed unit-to-class map, per-class latencies and unit states.
package sb_pkg;
    localparam int NUM_UNITS = 10;
    localparam int UNIT_W    = $clog2(NUM_UNITS);

    typedef enum logic [2:0] {
        CL_FMUL   = 3'd0,
        CL_FADD   = 3'd1,
        CL_FDIV   = 3'd2,
        CL_IADD   = 3'd3,
        CL_INCR   = 3'd4,
        CL_BOOL   = 3'd5,
        CL_SHIFT  = 3'd6,
        CL_BRANCH = 3'd7
    } unit_class_e;

    typedef enum logic [1:0] {
        U_IDLE    = 2'd0,
        U_WAIT_RD = 2'd1,
        U_EXEC    = 2'd2,
        U_WAIT_WR = 2'd3
    } unit_state_e;

    // Which class a given unit index serves.
    function automatic unit_class_e class_of(input int u);
        case (u)
            0, 1:    return CL_FMUL;
            2:       return CL_FADD;
            3:       return CL_FDIV;
            4:       return CL_IADD;
            5, 6:    return CL_INCR;
            7:       return CL_BOOL;
            8:       return CL_SHIFT;
            default: return CL_BRANCH;
        endcase
    endfunction

    // Execution latency in cycles for a class.
    function automatic int latency_of(input unit_class_e c);
        case (c)
            CL_FMUL: return 10;
            CL_FDIV: return 29;
            CL_FADD: return 4;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/sb_regstat.sv
// Register result-pending table. Each register has a pending flag and
// the index of the unit that will produce it.
// Assumes set and clear never target the same register in one cycle
// (issue is blocked while a destination is pending).
module sb_regstat #(
    parameter int NUM_REGS = 8,
    parameter int RW       = 3,
    parameter int UW       = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_en,
    input  logic [RW-1:0]                 set_reg,
    input  logic [UW-1:0]                 set_unit,
    input  logic                          clr_en,
    input  logic [RW-1:0]                 clr_reg,
    output logic [NUM_REGS-1:0]           pend,
    output logic [NUM_REGS-1:0][UW-1:0]   tag
);
    // Update pending flags and producer tags on write-back and issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            tag  <= '0;
        end else begin
            if (clr_en) pend[clr_reg] <= 1'b0;
            if (set_en) begin
                pend[set_reg] <= 1'b1;
                tag[set_reg]  <= set_unit;
            end
        end
    end
endmodule

// File: rtl/sb_fu.sv
// One functional unit slot: holds the issued instruction's registers,
// source tags and ready flags, and sequences wait-read, execute
// (fixed countdown of LAT cycles) and wait-write.
// Assumes issue_i is raised only while the unit is idle.
module sb_fu #(
    parameter int LAT = 3,
    parameter int RW  = 3,
    parameter int UW  = 4,
    parameter int NU  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [RW-1:0] dst_i,
    input  logic [RW-1:0] src1_i,
    input  logic [RW-1:0] src2_i,
    input  logic          rdy1_i,
    input  logic          rdy2_i,
    input  logic [UW-1:0] tag1_i,
    input  logic [UW-1:0] tag2_i,
    input  logic [NU-1:0] wr_bcast_i,
    input  logic          wr_grant_i,
    output logic          busy_o,
    output logic          wait_rd_o,
    output logic          done_o,
    output logic          rd_grant_o,
    output logic [RW-1:0] dst_o,
    output logic [RW-1:0] src1_o,
    output logic [RW-1:0] src2_o,
    output logic          rdy1_o,
    output logic          rdy2_o
);
    import sb_pkg::*;
    localparam int CW = $clog2(LAT + 1);

    unit_state_e   state;
    logic [CW-1:0] cnt;
    logic [UW-1:0] tag1, tag2;

    // Operands may be read once both sources are ready.
    assign rd_grant_o = (state == U_WAIT_RD) && rdy1_o && rdy2_o;
    assign busy_o     = (state != U_IDLE);
    assign wait_rd_o  = (state == U_WAIT_RD);
    assign done_o     = (state == U_WAIT_WR);

    // Unit state sequence and capture of the issued instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= U_IDLE;
            cnt    <= '0;
            dst_o  <= '0;
            src1_o <= '0;
            src2_o <= '0;
            rdy1_o <= 1'b0;
            rdy2_o <= 1'b0;
            tag1   <= '0;
            tag2   <= '0;
        end else begin
            case (state)
                U_IDLE: if (issue_i) begin
                    state  <= U_WAIT_RD;
                    dst_o  <= dst_i;
                    src1_o <= src1_i;
                    src2_o <= src2_i;
                    rdy1_o <= rdy1_i;
                    rdy2_o <= rdy2_i;
                    tag1   <= tag1_i;
                    tag2   <= tag2_i;
                end
                U_WAIT_RD: begin
                    if (rd_grant_o) begin
                        state <= U_EXEC;
                        cnt   <= CW'(LAT - 1);
                    end
                    if (!rdy1_o && wr_bcast_i[tag1]) rdy1_o <= 1'b1;
                    if (!rdy2_o && wr_bcast_i[tag2]) rdy2_o <= 1'b1;
                end
                U_EXEC: begin
                    if (cnt == '0) state <= U_WAIT_WR;
                    else           cnt   <= cnt - 1'b1;
                end
                default: if (wr_grant_i) state <= U_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sb_wb_arb.sv
// Write-back arbiter: a finished unit may write only if no other unit
// still waits to read its destination with that operand marked ready
// (write-after-read). Among eligible units the lowest index wins the
// single write port.
module sb_wb_arb #(
    parameter int NU = 10,
    parameter int RW = 3
) (
    input  logic [NU-1:0]         done,
    input  logic [NU-1:0]         wait_rd,
    input  logic [NU-1:0][RW-1:0] dst,
    input  logic [NU-1:0][RW-1:0] src1,
    input  logic [NU-1:0][RW-1:0] src2,
    input  logic [NU-1:0]         rdy1,
    input  logic [NU-1:0]         rdy2,
    output logic [NU-1:0]         grant
);
    logic [NU-1:0] war_blk;
    logic [NU-1:0] elig;
    logic          found;

    // Find units whose result would overwrite a value still to be read.
    always_comb begin
        war_blk = '0;
        for (int u = 0; u < NU; u++) begin
            for (int v = 0; v < NU; v++) begin
                if (v != u && wait_rd[v] &&
                    ((src1[v] == dst[u] && rdy1[v]) ||
                     (src2[v] == dst[u] && rdy2[v])))
                    war_blk[u] = 1'b1;
            end
        end
    end

    assign elig = done & ~war_blk;

    // Fixed priority by unit index for the one write port.
    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (!found && elig[u]) begin
                grant[u] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
// Scoreboard issue controller (top). Accepts one decoded instruction
// per cycle in program order, picks a free unit of its class, stalls
// on busy class or pending destination, records source dependencies,
// and drives per-unit read and write strobes.
// Assumes NUM_REGS is a power of two; the unit map is fixed in sb_pkg.
module sb_issue_ctrl #(
    parameter int NUM_REGS = 8,
    localparam int RW      = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [2:0]                    in_class,
    input  logic [RW-1:0]                 in_dst,
    input  logic [RW-1:0]                 in_src1,
    input  logic [RW-1:0]                 in_src2,
    output logic                          issue_ok,
    output logic [sb_pkg::NUM_UNITS-1:0]  issue_unit,
    output logic                          stall,
    output logic [sb_pkg::NUM_UNITS-1:0]  read_grant,
    output logic [sb_pkg::NUM_UNITS-1:0]  write_grant,
    output logic                          wb_valid,
    output logic [RW-1:0]                 wb_reg
);
    import sb_pkg::*;
    localparam int NU = NUM_UNITS;
    localparam int UW = UNIT_W;

    logic [NUM_REGS-1:0]         pend;
    logic [NUM_REGS-1:0][UW-1:0] tag;
    logic [NU-1:0]               fu_busy, fu_wait, fu_done, fu_rdy1, fu_rdy2;
    logic [NU-1:0][RW-1:0]       fu_dst, fu_src1, fu_src2;
    logic [NU-1:0]               free_match, sel;
    logic [UW-1:0]               sel_idx;
    logic                        found, waw;
    logic                        rdy1_new, rdy2_new;

    // Free units serving the requested class.
    always_comb begin
        for (int u = 0; u < NU; u++)
            free_match[u] = !fu_busy[u] && (class_of(u) == unit_class_e'(in_class));
    end

    // Lowest-index free unit of the class, and its index.
    always_comb begin
        sel     = '0;
        sel_idx = '0;
        found   = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (!found && free_match[u]) begin
                sel[u]  = 1'b1;
                sel_idx = UW'(u);
                found   = 1'b1;
            end
        end
    end

    assign waw        = pend[in_dst];
    assign issue_ok   = in_valid && found && !waw;
    assign stall      = in_valid && !issue_ok;
    assign issue_unit = issue_ok ? sel : '0;

    // A source is ready if not pending or its producer writes this cycle.
    assign rdy1_new = !pend[in_src1] || write_grant[tag[in_src1]];
    assign rdy2_new = !pend[in_src2] || write_grant[tag[in_src2]];

    // Destination of the unit that owns the write port this cycle.
    always_comb begin
        wb_reg = '0;
        for (int u = 0; u < NU; u++)
            if (write_grant[u]) wb_reg = fu_dst[u];
    end
    assign wb_valid = |write_grant;

    sb_regstat #(.NUM_REGS(NUM_REGS), .RW(RW), .UW(UW)) u_regstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue_ok),
        .set_reg  (in_dst),
        .set_unit (sel_idx),
        .clr_en   (wb_valid),
        .clr_reg  (wb_reg),
        .pend     (pend),
        .tag      (tag)
    );

    for (genvar g = 0; g < NU; g++) begin : g_fu
        sb_fu #(
            .LAT (latency_of(class_of(g))),
            .RW  (RW),
            .UW  (UW),
            .NU  (NU)
        ) u_fu (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue_i    (issue_unit[g]),
            .dst_i      (in_dst),
            .src1_i     (in_src1),
            .src2_i     (in_src2),
            .rdy1_i     (rdy1_new),
            .rdy2_i     (rdy2_new),
            .tag1_i     (tag[in_src1]),
            .tag2_i     (tag[in_src2]),
            .wr_bcast_i (write_grant),
            .wr_grant_i (write_grant[g]),
            .busy_o     (fu_busy[g]),
            .wait_rd_o  (fu_wait[g]),
            .done_o     (fu_done[g]),
            .rd_grant_o (read_grant[g]),
            .dst_o      (fu_dst[g]),
            .src1_o     (fu_src1[g]),
            .src2_o     (fu_src2[g]),
            .rdy1_o     (fu_rdy1[g]),
            .rdy2_o     (fu_rdy2[g])
        );
    end

    sb_wb_arb #(.NU(NU), .RW(RW)) u_arb (
        .done    (fu_done),
        .wait_rd (fu_wait),
        .dst     (fu_dst),
        .src1    (fu_src1),
        .src2    (fu_src2),
        .rdy1    (fu_rdy1),
        .rdy2    (fu_rdy2),
        .grant   (write_grant)
    );
endmodule

// File: rtl/sb_issue_chk.sv
// Protocol checker for sb_issue_ctrl, attached by bind. Observes only
// the top-level strobes.
module sb_issue_chk #(
    parameter int NU = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_ok,
    input logic          stall,
    input logic [NU-1:0] issue_unit,
    input logic [NU-1:0] read_grant,
    input logic [NU-1:0] write_grant
);
    // R1: no strobes in the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (read_grant == '0 && write_grant == '0));

    // R2: acceptance names exactly one unit and never coincides with stall
    assert_issue_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> ($countones(issue_unit) == 1 && !stall));

    // R8: one write port
    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(write_grant));

    for (genvar u = 0; u < NU; u++) begin : g_unit
        // R3: a unit just given an instruction is busy in the next cycle
        assert_busy_after_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
            issue_unit[u] |=> !issue_unit[u]);
        // R7: execution takes at least one cycle after the read
        assert_no_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
            read_grant[u] |=> !write_grant[u]);
        // R9: a unit that has written is idle next, so it cannot read
        assert_idle_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            write_grant[u] |=> !read_grant[u]);
    end
endmodule

bind sb_issue_ctrl sb_issue_chk #(.NU(sb_pkg::NUM_UNITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_ok    (issue_ok),
    .stall       (stall),
    .issue_unit  (issue_unit),
    .read_grant  (read_grant),
    .write_grant (write_grant)
);

// File: tb/sb_issue_ctrl_tb.sv
// Scoreboard bench: the driver pushes predicted write-backs into a
// queue; a monitor pops and compares each write-back as it appears.
module sb_issue_ctrl_tb;
    import sb_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int RW   = 3;
    localparam int NU   = NUM_UNITS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_class = '0;
    logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic          issue_ok, stall, wb_valid;
    logic [NU-1:0] issue_unit, read_grant, write_grant;
    logic [RW-1:0] wb_reg;

    typedef struct {
        int    unit;
        int    rg;
        int    cyc;
        string req;
    } wb_item_t;

    wb_item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sb_issue_ctrl #(.NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue_ok(issue_ok), .issue_unit(issue_unit), .stall(stall),
        .read_grant(read_grant), .write_grant(write_grant),
        .wb_valid(wb_valid), .wb_reg(wb_reg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_wb(input int unit, input int rg, input int c, input string req);
        wb_item_t it;
        it.unit = unit; it.rg = rg; it.cyc = c; it.req = req;
        q.push_back(it);
    endtask

    // Offer one instruction, hold it until accepted, return the issue cycle.
    task automatic drive(input unit_class_e cls, input int d, input int s1, input int s2,
                         input int exp_unit, output int ic);
        @(negedge clk);
        in_valid = 1'b1; in_class = cls;
        in_dst = RW'(d); in_src1 = RW'(s1); in_src2 = RW'(s2);
        #1;
        while (!issue_ok) begin
            @(negedge clk);
            #1;
        end
        ic = cyc;
        check(issue_unit == NU'(1) << exp_unit, "R2", "issue_unit",
              int'(issue_unit), 1 << exp_unit);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
        #3;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare each write-back with the head of the queue.
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished && write_grant != '0) begin
            int u;
            u = -1;
            for (int i = 0; i < NU; i++) if (write_grant[i]) u = i;
            check($countones(write_grant) == 1, "R8", "grants per cycle",
                  $countones(write_grant), 1);
            if (q.size() == 0) begin
                check(1'b0, "R7", "unexpected write unit", u, -1);
            end else begin
                wb_item_t it;
                it = q.pop_front();
                check(u == it.unit, it.req, "write unit", u, it.unit);
                check(int'(wb_reg) == it.rg && wb_valid, "R11", "wb_reg", int'(wb_reg), it.rg);
                check(cyc == it.cyc, it.req, "write cycle", cyc, it.cyc);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c, c1, c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1: reset state
        check(read_grant == '0, "R1", "read_grant", int'(read_grant), 0);
        check(write_grant == '0 && !wb_valid, "R1", "write_grant", int'(write_grant), 0);
        check(!stall && !issue_ok, "R1", "stall idle", int'(stall), 0);

        // Baseline integer add: read next cycle, write LAT+1 later (R5, R7)
        drive(CL_IADD, 1, 2, 3, 4, c);
        expect_wb(4, 1, c + 5, "R7");
        wait_until(c + 1);
        check(read_grant[4], "R5", "iadd read at issue+1", int'(read_grant[4]), 1);
        drain();

        // Out-of-order completion: divide then add (R10)
        drive(CL_FDIV, 2, 4, 5, 3, c);
        drive(CL_IADD, 3, 4, 5, 4, c1);
        check(c1 == c + 1, "R2", "back-to-back issue", c1, c + 1);
        expect_wb(4, 3, c + 6, "R10");
        expect_wb(3, 2, c + 31, "R7");
        drain();

        // Class exhaustion: third multiply waits for unit 0 (R3, R9)
        drive(CL_FMUL, 1, 6, 7, 0, c);
        expect_wb(0, 1, c + 12, "R3");
        expect_wb(1, 2, c + 13, "R3");
        expect_wb(0, 3, c + 25, "R3");
        drive(CL_FMUL, 2, 6, 7, 1, c1);
        drive(CL_FMUL, 3, 6, 7, 0, c2);
        check(c2 == c + 13, "R3", "third multiply issue cycle", c2, c + 13);
        drain();

        // Output dependency: boolean to the same register waits (R4)
        drive(CL_IADD, 1, 4, 5, 4, c);
        expect_wb(4, 1, c + 5, "R4");
        expect_wb(7, 1, c + 11, "R4");
        drive(CL_BOOL, 1, 4, 5, 7, c1);
        check(c1 == c + 6, "R4", "WAW issue cycle", c1, c + 6);
        drain();

        // True dependency: add waits to read multiply result (R5)
        drive(CL_FMUL, 1, 6, 7, 0, c);
        expect_wb(0, 1, c + 12, "R5");
        expect_wb(4, 2, c + 17, "R5");
        drive(CL_IADD, 2, 1, 3, 4, c1);
        check(c1 == c + 1, "R5", "dependent issue not stalled", c1, c + 1);
        wait_until(c + 2);
        check(!read_grant[4], "R5", "read held", int'(read_grant[4]), 0);
        wait_until(c + 13);
        check(read_grant[4], "R5", "read after producer write", int'(read_grant[4]), 1);
        drain();

        // Anti-dependency: boolean write held until add reads r3 (R6)
        drive(CL_FDIV, 1, 4, 5, 3, c);
        expect_wb(3, 1, c + 31, "R6");
        expect_wb(7, 3, c + 33, "R6");
        expect_wb(4, 2, c + 36, "R6");
        drive(CL_IADD, 2, 1, 3, 4, c1);
        drive(CL_BOOL, 3, 4, 5, 7, c2);
        check(c2 == c + 2, "R6", "boolean issue cycle", c2, c + 2);
        wait_until(c + 7);
        check(!write_grant[7], "R6", "write held", int'(write_grant[7]), 0);
        drain();

        // Priority tie and unit release (R8, R9)
        drive(CL_FADD, 1, 4, 5, 2, c);
        expect_wb(2, 1, c + 6, "R8");
        expect_wb(4, 2, c + 7, "R8");
        expect_wb(2, 3, c + 13, "R9");
        drive(CL_IADD, 2, 4, 5, 4, c1);
        drive(CL_FADD, 3, 4, 5, 2, c2);
        check(c2 == c + 7, "R9", "reissue after write", c2, c + 7);
        drain();

        check(q.size() == 0, "R7", "pending expectations", q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule